// File: doc/BRIEF.md
# Dual-Mode FIFO Read Output Stage

This block is the read-side end of a synchronous FIFO. It owns the output data register and a single status flag that tells the reader whether that register holds valid data. The memory array and all write-side logic sit outside it. The memory presents its head word and a not-empty indication that is already synchronized to the read clock. The block answers with a one-cycle take strobe. The memory pops its head word on the same rising edge and shows the next state of not-empty from the following cycle.

A mode input chooses between two behaviours. The block samples it only while reset is held. In fall-through mode, the block moves a word into the output register on its own as soon as one exists. The flag then means Output Ready, and a qualified read swaps in the next word. In standard mode, a word reaches the output register only through an explicit read. The flag then means "not Empty" and trails the memory by two read-clock edges. In both modes a high flag means data is available, and the qualified read request comes from the port decode logic.

Top module: `fifo_out_stage`

## Requirements
- R1: While reset is held and right after it is released, avail_o is 0, rdata_o is 0, and mem_take_o is 0 when the memory is empty.
- R2: Fall-through mode (mode input 1), flag low, memory not empty: mem_take_o is 1 in that cycle. On the next rising edge rdata_o takes the memory head word and avail_o goes high on that same edge.
- R3: Fall-through mode, flag high, rd_req_i high, memory not empty: mem_take_o is 1. On the edge the next word loads into rdata_o and avail_o stays high.
- R4: Fall-through mode, flag high, rd_req_i high, memory empty: avail_o goes low on that edge, rdata_o keeps its value, and mem_take_o stays 0.
- R5: Fall-through mode, flag high, rd_req_i low: mem_take_o is 0 and rdata_o and avail_o hold, even when the memory has words.
- R6: Standard mode (mode input 0): after the memory turns not empty, avail_o is still low after the first rising edge and is high after the second. No word is loaded without a read, and rdata_o keeps its value.
- R7: Standard mode, avail_o high and rd_req_i high: mem_take_o is 1 and rdata_o takes the head word on the edge. avail_o goes low on that edge and rises on the next edge if the memory is still not empty.
- R8: A read request while avail_o is low is ignored. rdata_o keeps its value and the request alone causes no take.
- R9: The mode input is sampled only while rst_n is low. Changing it during operation does not change the behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset; the mode is sampled while low |
| fwft_sel_i | input | 1 | Mode select: 1 fall-through, 0 standard |
| rd_req_i | input | 1 | Qualified read request from port decode |
| mem_rdata_i | input | DATA_W | Head word presented by the memory |
| mem_nempty_i | input | 1 | Synchronized memory not-empty indication |
| mem_take_o | output | 1 | Pops the head word on the coming edge |
| rdata_o | output | DATA_W | Output data register |
| avail_o | output | 1 | Output Ready (fall-through) or not-Empty (standard) |

## Verification
In fall-through mode the bench writes a single word into an empty memory, then two words while the output is held. Reads are then issued until the memory drains, and one more read follows while the flag is low. This separates automatic prefetch from read-driven advance and shows that an underflowing read is dropped. In standard mode it issues a read against an empty stage and then writes one word. This shows the two-edge flag delay and the absence of an automatic load. Back-to-back reads across two words show the one-cycle flag gap after each read. Each mode is also run with the mode pin flipped mid-operation, which shows that only the value held during reset counts.

// File: rtl/fos_pkg.sv
package fos_pkg;
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fos_mode_e;

    typedef struct packed {
        logic flag;
        logic seen;
    } fos_ctl_t;
endpackage

// File: rtl/fos_mode_latch.sv
module fos_mode_latch
    import fos_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sel_i,
    output fos_mode_e mode_o
);
    fos_mode_e mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (!rst_n) begin
            mode_d = sel_i ? MODE_FWFT : MODE_STD;
        end
    end

    always_ff @(posedge clk) begin
        mode_q <= mode_d;
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/fos_flag_ctrl.sv
module fos_flag_ctrl
    import fos_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  fos_mode_e mode_i,
    input  logic      rd_i,
    input  logic      nempty_i,
    output logic      take_o,
    output logic      flag_o
);
    fos_ctl_t ctl_d, ctl_q;
    logic     take;

    always_comb begin
        ctl_d = ctl_q;
        take  = 1'b0;
        if (mode_i == MODE_FWFT) begin
            take       = nempty_i & (~ctl_q.flag | rd_i);
            ctl_d.seen = 1'b0;
            if (!ctl_q.flag || rd_i) begin
                ctl_d.flag = nempty_i;
            end
        end else begin
            take       = ctl_q.flag & rd_i;
            ctl_d.seen = nempty_i;
            ctl_d.flag = ctl_q.seen & nempty_i & ~take;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign take_o = take;
    assign flag_o = ctl_q.flag;
endmodule

// File: rtl/fos_out_reg.sv
module fos_out_reg #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o
);
    logic [DATA_W-1:0] dout_d, dout_q;

    always_comb begin
        dout_d = dout_q;
        if (load_i) begin
            dout_d = din_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else begin
            dout_q <= dout_d;
        end
    end

    assign dout_o = dout_q;
endmodule

// File: rtl/fifo_out_stage.sv
module fifo_out_stage
    import fos_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fwft_sel_i,
    input  logic              rd_req_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_nempty_i,
    output logic              mem_take_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              avail_o
);
    fos_mode_e mode;
    logic      take;

    fos_mode_latch u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (fwft_sel_i),
        .mode_o (mode)
    );

    fos_flag_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode),
        .rd_i     (rd_req_i),
        .nempty_i (mem_nempty_i),
        .take_o   (take),
        .flag_o   (avail_o)
    );

    fos_out_reg #(.DATA_W(DATA_W)) u_oreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (take),
        .din_i  (mem_rdata_i),
        .dout_o (rdata_o)
    );

    assign mem_take_o = take;
endmodule

// File: rtl/fifo_out_stage_chk.sv
module fifo_out_stage_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fwft,
    input logic              rd_req_i,
    input logic [DATA_W-1:0] mem_rdata_i,
    input logic              mem_nempty_i,
    input logic              mem_take_o,
    input logic [DATA_W-1:0] rdata_o,
    input logic              avail_o
);
    // R2
    prefetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwft && !avail_o && mem_nempty_i |=> avail_o && rdata_o == $past(mem_rdata_i));

    // R4
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwft && avail_o && rd_req_i && !mem_nempty_i |=> !avail_o && $stable(rdata_o));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwft && avail_o && !rd_req_i |=> avail_o && $stable(rdata_o));

    // R7
    std_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fwft && mem_take_o |=> !avail_o);

    // R8
    ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !avail_o && !mem_nempty_i |=> $stable(rdata_o));

    // R9
    mode_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(fwft));
endmodule

bind fifo_out_stage fifo_out_stage_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fwft         (mode == fos_pkg::MODE_FWFT),
    .rd_req_i     (rd_req_i),
    .mem_rdata_i  (mem_rdata_i),
    .mem_nempty_i (mem_nempty_i),
    .mem_take_o   (mem_take_o),
    .rdata_o      (rdata_o),
    .avail_o      (avail_o)
);

// File: tb/fifo_out_stage_tb.sv
module fifo_out_stage_tb;
    localparam int DATA_W = 36;
    localparam time CLK_PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fwft_sel = 1'b1;
    logic              rd_req = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              mem_nempty = 1'b0;
    logic              mem_take;
    logic [DATA_W-1:0] rdata;
    logic              avail;

    logic [DATA_W-1:0] memq[$];
    logic [DATA_W-1:0] sb[$];
    logic              pend = 1'b0;
    int                n_vec = 0;
    int                n_err = 0;
    bit                done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_out_stage #(.DATA_W(DATA_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fwft_sel_i   (fwft_sel),
        .rd_req_i     (rd_req),
        .mem_rdata_i  (mem_rdata),
        .mem_nempty_i (mem_nempty),
        .mem_take_o   (mem_take),
        .rdata_o      (rdata),
        .avail_o      (avail)
    );

    task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one read-clock cycle; memory model pops on the edge after a take.
    task automatic step(input bit push, input logic [DATA_W-1:0] w, input bit rd,
                        input bit exp_take, input string tag);
        @(negedge clk);
        if (push) memq.push_back(w);
        rd_req     = rd;
        mem_nempty = (memq.size() > 0);
        mem_rdata  = (memq.size() > 0) ? memq[0] : '0;
        #1;
        chk({tag, " take"}, DATA_W'(mem_take), DATA_W'(exp_take));
        pend = mem_take;
        if (pend) sb.push_back(mem_rdata);
        @(posedge clk);
        #1;
        if (pend) begin
            void'(memq.pop_front());
            // Monitor: the loaded word must match the oldest taken word.
            chk({tag, " scoreboard"}, rdata, sb.pop_front());
        end
    endtask

    task automatic do_reset(input bit mode);
        @(negedge clk);
        rst_n = 1'b0;
        fwft_sel = mode;
        rd_req = 1'b0;
        mem_nempty = 1'b0;
        memq.delete();
        sb.delete();
        repeat (3) @(negedge clk);
        chk("R1 flag in reset", DATA_W'(avail), '0);
        chk("R1 data in reset", rdata, '0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 flag after reset", DATA_W'(avail), '0);
        chk("R1 data after reset", rdata, '0);
        chk("R1 take after reset", DATA_W'(mem_take), '0);
    endtask

    initial begin
        do_reset(1'b1);
        // fall-through mode
        step(1, 36'h0_0000_00A1, 0, 1, "R2");
        chk("R2 flag", DATA_W'(avail), 1);
        chk("R2 data", rdata, 36'h0_0000_00A1);
        step(0, '0, 0, 0, "R5");
        step(1, 36'h0_0000_00B2, 0, 0, "R5");
        step(1, 36'h0_0000_00C3, 0, 0, "R5");
        chk("R5 hold data", rdata, 36'h0_0000_00A1);
        chk("R5 hold flag", DATA_W'(avail), 1);
        step(0, '0, 1, 1, "R3");
        chk("R3 data", rdata, 36'h0_0000_00B2);
        chk("R3 flag", DATA_W'(avail), 1);
        step(0, '0, 1, 1, "R3");
        chk("R3 data2", rdata, 36'h0_0000_00C3);
        step(0, '0, 1, 0, "R4");
        chk("R4 flag", DATA_W'(avail), 0);
        chk("R4 data", rdata, 36'h0_0000_00C3);
        step(0, '0, 1, 0, "R8");
        chk("R8 data fwft", rdata, 36'h0_0000_00C3);
        chk("R8 flag fwft", DATA_W'(avail), 0);
        fwft_sel = 1'b0;
        step(1, 36'h0_0000_00D4, 0, 1, "R9");
        chk("R9 still prefetches", rdata, 36'h0_0000_00D4);
        chk("R9 flag", DATA_W'(avail), 1);
        step(0, '0, 1, 0, "R4");

        // standard mode
        do_reset(1'b0);
        step(0, '0, 1, 0, "R8");
        chk("R8 data std", rdata, '0);
        step(1, 36'h0_0000_00E5, 0, 0, "R6");
        chk("R6 flag edge1", DATA_W'(avail), 0);
        step(0, '0, 0, 0, "R6");
        chk("R6 flag edge2", DATA_W'(avail), 1);
        chk("R6 no autoload", rdata, '0);
        step(1, 36'h0_0000_00F6, 1, 1, "R7");
        chk("R7 data", rdata, 36'h0_0000_00E5);
        chk("R7 flag drop", DATA_W'(avail), 0);
        step(0, '0, 1, 0, "R8");
        chk("R8 data gap", rdata, 36'h0_0000_00E5);
        chk("R7 flag back", DATA_W'(avail), 1);
        step(0, '0, 1, 1, "R7");
        chk("R7 data2", rdata, 36'h0_0000_00F6);
        step(0, '0, 0, 0, "R7");
        chk("R7 empty flag", DATA_W'(avail), 0);
        fwft_sel = 1'b1;
        step(1, 36'h0_0000_0107, 0, 0, "R9");
        chk("R9 flag edge1", DATA_W'(avail), 0);
        step(0, '0, 0, 0, "R9");
        chk("R9 flag edge2", DATA_W'(avail), 1);
        chk("R9 no autoload", rdata, 36'h0_0000_00F6);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end
endmodule